// File: doc/BRIEF.md
# Multi-Channel Periodic Interrupt Timer

A bank of independent down-counting timer channels behind a small register bus. Each channel holds a reload value. When it is enabled it counts down by one on every cycle in which the shared tick input is high. When a step happens at a count of zero, the channel copies the reload value back into the counter, latches its event flag and keeps running. Software does not need to act to keep the timer periodic. Each channel drives its own interrupt line, which is high while the flag is set and the channel's interrupt enable is on.

A global halt bit stops every channel at once. A channel can be linked to the channel below it. A linked channel then counts the wrap events of that lower channel instead of ticks, so pairs of channels can form a wider timer. Writing a new reload value never cuts short the period already in progress. The new value takes effect at the next wrap, or when the channel goes from stopped to running.

Top module: `intr_timer_bank`

## Requirements
- R1: After reset, every channel register reads zero, the global register reads 0x2 (halt set), bus read data is zero and all interrupt lines are low.
- R2: The global register sits at byte offset 0x000. Channel n occupies 0x100 + 0x10·n, with the reload value at +0x0, the live count at +0x4, control at +0x8 and the flag at +0xC. Any other address reads zero. Read data appears on the bus one clock edge after the read strobe and holds until the next read.
- R3: Control bit 0 runs the channel, bit 1 enables its interrupt and bit 2 links it to the channel below. A 0→1 transition of the run bit copies the reload value into the count. While the run bit is 0, the count holds.
- R4: A running channel decrements on each tick. A step taken at count zero reloads the count and sets the flag, so one period spans reload+1 ticks.
- R5: While bit 1 of the global register is 1, no channel steps: counts and flags hold.
- R6: Writing the reload value leaves the live count unchanged. The new value is used at the next wrap.
- R7: Flag bit 0 is cleared by writing 1 to it. Writing 0 has no effect. A wrap in the same cycle as a clearing write leaves the flag set.
- R8: A channel's interrupt line is high exactly when its flag and its interrupt enable are both set.
- R9: A linked channel n>0 steps once per wrap of channel n−1 and ignores the tick. The link bit has no effect on channel 0.
- R10: While the tick input is low, unlinked channels do not step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Count enable shared by unlinked channels |
| bus_addr_i | input | ADDR_W (12) | Byte address |
| bus_wdata_i | input | DATA_W (32) | Write data |
| bus_wr_i | input | 1 | Write strobe, one cycle per access |
| bus_rd_i | input | 1 | Read strobe, one cycle per access |
| bus_rdata_o | output | DATA_W (32) | Registered read data |
| irq_o | output | NUM_CH (4) | Per-channel interrupt lines |

## Verification
A write takes effect at the clock edge that samples its strobe. A read returns the state as it was just before that edge, so a read issued while the channels are halted reports a stable count. Because the run transition copies the reload value at its write edge, the flag rises exactly reload+1 edges after that edge, or after the edge that clears the halt bit. The bench therefore drives on falling edges, counts edges one by one from each write and checks the interrupt line at every falling edge of the window. It checks that the line is low right up to the expected edge and high at that edge. For a linked pair, the window is the product of both periods. The bench also times a clearing write so that it lands on the wrap edge.

// File: rtl/itb_pkg.sv
package itb_pkg;

    // Register selector inside one channel window (address bits [3:2]).
    typedef enum logic [1:0] {
        SEL_RELOAD = 2'd0,
        SEL_COUNT  = 2'd1,
        SEL_CTRL   = 2'd2,
        SEL_FLAG   = 2'd3
    } ch_sel_e;

    // Control field positions.
    localparam int CTL_RUN  = 0;
    localparam int CTL_IE   = 1;
    localparam int CTL_LINK = 2;

    // Global register: halt bit position.
    localparam int GLB_HALT = 1;

    // Channel window placement.
    localparam int WIN_BASE = 'h100;
    localparam int WIN_SPAN = 'h10;

endpackage

// File: rtl/itb_decode.sv
module itb_decode
    import itb_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic              glb_hit_o,
    output logic [NUM_CH-1:0] ch_hit_o,
    output ch_sel_e           sel_o
);
    localparam int HI_W = ADDR_W - 4;

    always_comb begin
        glb_hit_o = (addr_i == '0);
        sel_o     = ch_sel_e'(addr_i[3:2]);
        ch_hit_o  = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            ch_hit_o[i] = (addr_i[ADDR_W-1:4] == HI_W'(WIN_BASE / WIN_SPAN + i))
                          && (addr_i[1:0] == 2'b00);
        end
    end
endmodule

// File: rtl/itb_channel.sv
module itb_channel
    import itb_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int DATA_W = 32,
    parameter bit FIRST  = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              halt_i,
    input  logic              prev_zero_i,
    input  logic              wr_reload_i,
    input  logic              wr_ctrl_i,
    input  logic              wr_flag_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [CNT_W-1:0]  reload_o,
    output logic [CNT_W-1:0]  count_o,
    output logic [2:0]        ctrl_o,
    output logic              flag_o,
    output logic              zero_o,
    output logic              irq_o
);
    typedef struct packed {
        logic [CNT_W-1:0] reload;
        logic [CNT_W-1:0] count;
        logic             run;
        logic             ie;
        logic             link;
        logic             flag;
    } chan_t;

    chan_t st_q, st_d;
    logic  src, step, wrap;

    always_comb begin
        src = tick_i;
        if (!FIRST && st_q.link) begin
            src = prev_zero_i;
        end
        step = st_q.run && !halt_i && src;
        wrap = step && (st_q.count == '0);

        st_d = st_q;
        if (step) begin
            st_d.count = wrap ? st_q.reload : st_q.count - CNT_W'(1);
        end
        if (wr_reload_i) begin
            st_d.reload = wdata_i[CNT_W-1:0];
        end
        if (wr_ctrl_i) begin
            st_d.run  = wdata_i[CTL_RUN];
            st_d.ie   = wdata_i[CTL_IE];
            st_d.link = wdata_i[CTL_LINK];
            if (wdata_i[CTL_RUN] && !st_q.run) begin
                st_d.count = st_q.reload;
            end
        end
        if (wr_flag_i && wdata_i[0]) begin
            st_d.flag = 1'b0;
        end
        if (wrap) begin
            st_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign reload_o = st_q.reload;
    assign count_o  = st_q.count;
    assign ctrl_o   = {st_q.link, st_q.ie, st_q.run};
    assign flag_o   = st_q.flag;
    assign zero_o   = wrap;
    assign irq_o    = st_q.flag & st_q.ie;
endmodule

// File: rtl/intr_timer_bank.sv
module intr_timer_bank
    import itb_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 32,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic [NUM_CH-1:0] irq_o
);
    localparam int FLAT_W = NUM_CH * CNT_W;

    typedef struct packed {
        logic              halt;
        logic [DATA_W-1:0] rdata;
    } top_t;

    top_t st_q, st_d;

    logic              glb_hit;
    logic [NUM_CH-1:0] ch_hit;
    ch_sel_e           sel;

    logic [CNT_W-1:0]  ch_reload [NUM_CH];
    logic [CNT_W-1:0]  ch_count  [NUM_CH];
    logic [2:0]        ch_ctrl   [NUM_CH];
    logic [NUM_CH-1:0] ch_flag, ch_zero, ch_prev, ch_run;
    logic [NUM_CH-1:0] wr_rel, wr_ctl, wr_flg;
    logic [FLAT_W-1:0] cnt_flat, rel_flat;
    logic              mod_halt;

    itb_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
        .addr_i    (bus_addr_i),
        .glb_hit_o (glb_hit),
        .ch_hit_o  (ch_hit),
        .sel_o     (sel)
    );

    assign mod_halt = st_q.halt;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        if (g == 0) begin : g_head
            assign ch_prev[g] = 1'b0;
        end else begin : g_tail
            assign ch_prev[g] = ch_zero[g-1];
        end

        assign wr_rel[g] = bus_wr_i && ch_hit[g] && (sel == SEL_RELOAD);
        assign wr_ctl[g] = bus_wr_i && ch_hit[g] && (sel == SEL_CTRL);
        assign wr_flg[g] = bus_wr_i && ch_hit[g] && (sel == SEL_FLAG);

        itb_channel #(
            .CNT_W  (CNT_W),
            .DATA_W (DATA_W),
            .FIRST  (g == 0)
        ) u_chan (
            .clk         (clk),
            .rst_n       (rst_n),
            .tick_i      (tick_i),
            .halt_i      (mod_halt),
            .prev_zero_i (ch_prev[g]),
            .wr_reload_i (wr_rel[g]),
            .wr_ctrl_i   (wr_ctl[g]),
            .wr_flag_i   (wr_flg[g]),
            .wdata_i     (bus_wdata_i),
            .reload_o    (ch_reload[g]),
            .count_o     (ch_count[g]),
            .ctrl_o      (ch_ctrl[g]),
            .flag_o      (ch_flag[g]),
            .zero_o      (ch_zero[g]),
            .irq_o       (irq_o[g])
        );

        assign ch_run[g]                     = ch_ctrl[g][CTL_RUN];
        assign cnt_flat[g*CNT_W +: CNT_W]    = ch_count[g];
        assign rel_flat[g*CNT_W +: CNT_W]    = ch_reload[g];
    end

    always_comb begin
        st_d = st_q;
        if (bus_wr_i && glb_hit) begin
            st_d.halt = bus_wdata_i[GLB_HALT];
        end
        if (bus_rd_i) begin
            st_d.rdata = '0;
            if (glb_hit) begin
                st_d.rdata = DATA_W'({st_q.halt, 1'b0});
            end
            for (int i = 0; i < NUM_CH; i++) begin
                if (ch_hit[i]) begin
                    case (sel)
                        SEL_RELOAD: st_d.rdata = DATA_W'(ch_reload[i]);
                        SEL_COUNT:  st_d.rdata = DATA_W'(ch_count[i]);
                        SEL_CTRL:   st_d.rdata = DATA_W'(ch_ctrl[i]);
                        default:    st_d.rdata = DATA_W'(ch_flag[i]);
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.halt  <= 1'b1;
            st_q.rdata <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata_o = st_q.rdata;
endmodule

// File: rtl/itb_checker.sv
module itb_checker #(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 32,
    parameter int DATA_W = 32
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     halt,
    input logic                     bus_wr,
    input logic                     bus_rd,
    input logic [DATA_W-1:0]        rdata,
    input logic [NUM_CH*CNT_W-1:0]  cnt_flat,
    input logic [NUM_CH*CNT_W-1:0]  rel_flat,
    input logic [NUM_CH-1:0]        run,
    input logic [NUM_CH-1:0]        flag,
    input logic [NUM_CH-1:0]        zero,
    input logic [NUM_CH-1:0]        irq
);
    // R5: halted and no bus write -> counts and flags frozen
    a_r5_halt_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !bus_wr) |=> ($stable(cnt_flat) && $stable(flag)));

    // R2: read data only changes on a read
    a_r2_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(rdata));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        // R4: a wrap reloads the count from the reload value
        a_r4_wrap_reloads: assert property (@(posedge clk) disable iff (!rst_n)
            zero[i] |=> (cnt_flat[i*CNT_W +: CNT_W] == $past(rel_flat[i*CNT_W +: CNT_W])));

        // R7: a wrap leaves the flag set even against a clearing write
        a_r7_wrap_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
            zero[i] |=> flag[i]);

        // R3: a stopped channel with no write keeps its count
        a_r3_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
            (!run[i] && !bus_wr) |=> $stable(cnt_flat[i*CNT_W +: CNT_W]));

        // R8: an interrupt line never rises without a flag
        a_r8_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
            irq[i] |-> flag[i]);
    end
endmodule

bind intr_timer_bank itb_checker #(
    .NUM_CH (NUM_CH),
    .CNT_W  (CNT_W),
    .DATA_W (DATA_W)
) u_itb_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .halt     (mod_halt),
    .bus_wr   (bus_wr_i),
    .bus_rd   (bus_rd_i),
    .rdata    (bus_rdata_o),
    .cnt_flat (cnt_flat),
    .rel_flat (rel_flat),
    .run      (ch_run),
    .flag     (ch_flag),
    .zero     (ch_zero),
    .irq      (irq_o)
);

// File: tb/intr_timer_bank_bench.sv
module intr_timer_bank_bench;
    localparam int NUM_CH = 4;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam logic [ADDR_W-1:0] O_REL = 12'h0, O_CNT = 12'h4, O_CTL = 12'h8, O_FLG = 12'hC;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic [DATA_W-1:0] wdata = '0;
    logic              wr = 1'b0;
    logic              rd = 1'b0;
    logic [DATA_W-1:0] rdata;
    logic [NUM_CH-1:0] irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    intr_timer_bank u_intr_timer_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_wr_i    (wr),
        .bus_rd_i    (rd),
        .bus_rdata_o (rdata),
        .irq_o       (irq)
    );

    function automatic logic [ADDR_W-1:0] ca(int n, logic [ADDR_W-1:0] off);
        return ADDR_W'(12'h100 + 16 * n) + off;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rd_reg(logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
        addr = a; rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        d = rdata;
    endtask

    task automatic t_reset();
        logic [DATA_W-1:0] v;
        check("R1 irq after reset", 32'(irq), 0);
        check("R1 rdata after reset", rdata, 0);
        rd_reg(12'h000, v); check("R1 global reset value", v, 32'h2);
        for (int c = 0; c < NUM_CH; c++) begin
            rd_reg(ca(c, O_REL), v); check("R1 reload reset", v, 0);
            rd_reg(ca(c, O_CNT), v); check("R1 count reset", v, 0);
            rd_reg(ca(c, O_CTL), v); check("R1 ctrl reset", v, 0);
            rd_reg(ca(c, O_FLG), v); check("R1 flag reset", v, 0);
        end
        wr_reg(ca(2, O_REL), 32'hABCD);
        rd_reg(12'h004, v); check("R2 unmapped 0x004", v, 0);
        rd_reg(12'h140, v); check("R2 unmapped 0x140", v, 0);
        rd_reg(ca(2, 12'h2), v); check("R2 unaligned read", v, 0);
        rd_reg(ca(2, O_REL), v); check("R2 reload readback", v, 32'hABCD);
    endtask

    task automatic t_period();
        logic [DATA_W-1:0] v;
        wr_reg(ca(0, O_REL), 3);
        wr_reg(ca(0, O_CTL), 32'h3);
        rd_reg(ca(0, O_CNT), v); check("R3 enable loads count", v, 3);
        wr_reg(12'h000, 0);                     // unhalt at edge H
        check("R4 irq low at H", 32'(irq[0]), 0);
        for (int k = 1; k <= 3; k++) begin
            @(negedge clk); check("R4 irq low inside period", 32'(irq[0]), 0);
        end
        @(negedge clk); check("R4 irq high after reload+1 ticks", 32'(irq[0]), 1);
        wr_reg(ca(0, O_FLG), 1);                // lands H+5
        check("R7 write-1 clears flag", 32'(irq[0]), 0);
        @(negedge clk); check("R4 second period low", 32'(irq[0]), 0);
        @(negedge clk);
        wr_reg(ca(0, O_FLG), 1);                // lands on wrap edge H+8
        check("R7 set wins over clear", 32'(irq[0]), 1);
        wr_reg(12'h000, 32'h2);                 // halt, one more step
        rd_reg(ca(0, O_CNT), v); check("R4 count after reload", v, 2);
        wr_reg(ca(0, O_FLG), 0);
        rd_reg(ca(0, O_FLG), v); check("R7 write-0 keeps flag", v, 1);
        check("R8 irq with flag and ie", 32'(irq[0]), 1);
        wr_reg(ca(0, O_FLG), 1);
        rd_reg(ca(0, O_FLG), v); check("R7 flag cleared", v, 0);
    endtask

    task automatic t_halt_tick();
        logic [DATA_W-1:0] v;
        repeat (5) @(negedge clk);
        rd_reg(ca(0, O_CNT), v); check("R5 halt holds count", v, 2);
        check("R5 halt holds flag", 32'(irq[0]), 0);
        tick = 1'b0;
        wr_reg(12'h000, 0);
        repeat (5) @(negedge clk);
        rd_reg(ca(0, O_CNT), v); check("R10 tick low holds count", v, 2);
        wr_reg(12'h000, 32'h2);
        tick = 1'b1;
        wr_reg(ca(0, O_CTL), 0);
    endtask

    task automatic t_reload_write();
        logic [DATA_W-1:0] v;
        wr_reg(ca(1, O_REL), 5);
        wr_reg(ca(1, O_CTL), 32'h3);
        wr_reg(ca(1, O_REL), 20);
        rd_reg(ca(1, O_CNT), v); check("R6 count untouched by reload write", v, 5);
        rd_reg(ca(1, O_REL), v); check("R6 reload readback", v, 20);
        wr_reg(12'h000, 0);                     // unhalt at H
        check("R6 irq low at H", 32'(irq[1]), 0);
        for (int k = 1; k <= 5; k++) begin
            @(negedge clk); check("R6 old period still running", 32'(irq[1]), 0);
        end
        @(negedge clk); check("R6 wrap after old period", 32'(irq[1]), 1);
        wr_reg(12'h000, 32'h2);                 // one more step at H+7
        rd_reg(ca(1, O_CNT), v); check("R6 new reload used at wrap", v, 19);
        wr_reg(ca(1, O_CTL), 0);
        wr_reg(12'h000, 0);
        repeat (4) @(negedge clk);
        rd_reg(ca(1, O_CNT), v); check("R3 stopped count holds", v, 19);
        wr_reg(12'h000, 32'h2);
        wr_reg(ca(1, O_CTL), 32'h3);
        rd_reg(ca(1, O_CNT), v); check("R3 re-enable reloads", v, 20);
        wr_reg(ca(1, O_CTL), 0);
        wr_reg(ca(1, O_FLG), 1);
        wr_reg(ca(0, O_FLG), 1);
    endtask

    task automatic t_link();
        logic [DATA_W-1:0] v;
        wr_reg(ca(0, O_REL), 2);
        wr_reg(ca(1, O_REL), 1);
        wr_reg(ca(0, O_CTL), 32'h1);            // run, no ie
        wr_reg(ca(1, O_CTL), 32'h7);            // run, ie, link
        wr_reg(12'h000, 0);                     // unhalt at H
        check("R9 linked irq low at H", 32'(irq[1]), 0);
        for (int k = 1; k <= 5; k++) begin
            @(negedge clk);
            check("R9 linked irq low", 32'(irq[1]), 0);
            check("R8 no irq without ie", 32'(irq[0]), 0);
        end
        @(negedge clk); check("R9 linked wrap after two lower wraps", 32'(irq[1]), 1);
        wr_reg(12'h000, 32'h2);
        rd_reg(ca(1, O_CNT), v); check("R9 linked ignores tick", v, 1);
        rd_reg(ca(0, O_FLG), v); check("R8 flag set while irq low", v, 1);
        check("R8 irq stays low with ie off", 32'(irq[0]), 0);
    endtask

    task automatic t_link_first();
        wr_reg(ca(1, O_CTL), 0);
        wr_reg(ca(0, O_CTL), 0);
        wr_reg(ca(0, O_FLG), 1);
        wr_reg(ca(0, O_REL), 1);
        wr_reg(ca(0, O_CTL), 32'h7);
        wr_reg(12'h000, 0);                     // unhalt at H
        check("R9 ch0 link ignored, low at H", 32'(irq[0]), 0);
        @(negedge clk); check("R9 ch0 link ignored, low at H+1", 32'(irq[0]), 0);
        @(negedge clk); check("R9 ch0 link ignored, wraps on ticks", 32'(irq[0]), 1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog R1..all actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_period();
        t_halt_tick();
        t_reload_write();
        t_link();
        t_link_first();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule